// File: doc/BRIEF.md
# Single-Bit Manipulation Unit

This block carries out one-bit operations on either a byte-wide operand or a full 32-bit register value. A single flag, T, works as a one-bit accumulator. An operation either folds the chosen bit into T, or writes T (or a constant) back into the chosen bit. The caller supplies these inputs:

- an operation code
- a width select
- a bit index
- the operand value
- the current T flag

The block returns these outputs:

- the updated operand and a write strobe for it
- the new T value and a write strobe for it

Fetching and writing back a memory byte is left to the surrounding pipeline. The block only computes the new values.

The logic is combinational. By default it is followed by one output register with a synchronous, active-high reset, so results appear one clock after the inputs. The parameter `REG_OUT` set to 0 removes the register. In that case the outputs follow the inputs in the same cycle.

In byte mode only the low three index bits select the bit, and operand bits above bit 7 pass through untouched. In register mode the full five-bit index is used.

Top module: `bitop_unit`

## Requirements
- R1: Operation codes 0 (AND), 1 (OR) and 2 (XOR) combine the selected operand bit with T using that function. They place the result in T and raise `t_we`.
- R2: Code 3 ANDs T with the inverse of the selected bit, and code 4 ORs T with the inverse of the selected bit. The result goes to T and `t_we` is raised.
- R3: Code 5 forces the selected bit to 1 and code 6 forces it to 0. Both raise `opnd_we`.
- R4: Code 7 writes the incoming T value into the selected bit and raises `opnd_we`.
- R5: Code 8 copies the selected bit into T, and code 9 copies its inverse into T. Both raise `t_we`.
- R6: When `wide` is 0 (byte mode), the bit position is `idx[2:0]`, `idx[4:3]` has no effect, and `result[31:8]` equals `operand[31:8]`. When `wide` is 1, the position is the full `idx`.
- R7: For codes 5 to 7, every operand bit except the selected one is unchanged. `t_we` stays low and `t_out` equals `t_in`.
- R8: For codes 0 to 4, 8 and 9, `result` equals `operand` and `opnd_we` stays low.
- R9: Codes 10 to 15 raise neither strobe, return `operand` unchanged on `result`, and return `t_in` on `t_out`.
- R10: With `REG_OUT`=1, outputs reflect the inputs sampled at the previous rising clock edge. While `rst` is high at an edge, all outputs are cleared to zero. `opnd_we` and `t_we` are never high together.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock for the output register stage |
| rst | input | 1 | Synchronous active-high reset of the output stage |
| op | input | 4 | Operation code (0-9 defined, 10-15 reserved) |
| wide | input | 1 | 1 = 32-bit register operand, 0 = byte operand |
| idx | input | 5 | Bit index |
| operand | input | 32 | Operand value |
| t_in | input | 1 | Current T flag |
| result | output | 32 | Updated operand value |
| opnd_we | output | 1 | Write strobe for the operand |
| t_out | output | 1 | New T flag |
| t_we | output | 1 | Write strobe for T |

## Verification
On every cycle the assertions check four things:

- the two write strobes are mutually exclusive;
- an operand left unwritten and a T left unwritten equal the values sampled one edge earlier;
- an operand write changes at most one bit;
- a byte-mode result keeps the upper 24 bits.

Only the bench scenarios can show which bit is chosen and which logical function or constant lands there. The same goes for the inverted forms, the masking of the upper index bits in byte mode, and the clearing of the outputs by reset.

// File: rtl/bitop_pkg.sv
package bitop_pkg;

    localparam int OPC_W = 4;

    // operation codes; 10..15 are reserved
    localparam logic [OPC_W-1:0] OPC_AND   = 4'd0;
    localparam logic [OPC_W-1:0] OPC_OR    = 4'd1;
    localparam logic [OPC_W-1:0] OPC_XOR   = 4'd2;
    localparam logic [OPC_W-1:0] OPC_ANDN  = 4'd3;
    localparam logic [OPC_W-1:0] OPC_ORN   = 4'd4;
    localparam logic [OPC_W-1:0] OPC_SET   = 4'd5;
    localparam logic [OPC_W-1:0] OPC_CLR   = 4'd6;
    localparam logic [OPC_W-1:0] OPC_STORE = 4'd7;
    localparam logic [OPC_W-1:0] OPC_LOAD  = 4'd8;
    localparam logic [OPC_W-1:0] OPC_LOADN = 4'd9;

    typedef enum logic [2:0] {
        K_NONE,
        K_AND,
        K_OR,
        K_XOR,
        K_SET,
        K_CLR,
        K_STO,
        K_LD
    } bkind_e;

    typedef struct packed {
        bkind_e kind;
        logic   inv;      // use the inverse of the selected bit
        logic   to_t;     // destination is T
        logic   to_opnd;  // destination is the operand
    } bctrl_t;

    function automatic bctrl_t decode_op(input logic [OPC_W-1:0] opc);
        bctrl_t c;
        c.kind    = K_NONE;
        c.inv     = 1'b0;
        c.to_t    = 1'b0;
        c.to_opnd = 1'b0;
        case (opc)
            OPC_AND:   begin c.kind = K_AND; c.to_t = 1'b1; end
            OPC_OR:    begin c.kind = K_OR;  c.to_t = 1'b1; end
            OPC_XOR:   begin c.kind = K_XOR; c.to_t = 1'b1; end
            OPC_ANDN:  begin c.kind = K_AND; c.to_t = 1'b1; c.inv = 1'b1; end
            OPC_ORN:   begin c.kind = K_OR;  c.to_t = 1'b1; c.inv = 1'b1; end
            OPC_SET:   begin c.kind = K_SET; c.to_opnd = 1'b1; end
            OPC_CLR:   begin c.kind = K_CLR; c.to_opnd = 1'b1; end
            OPC_STORE: begin c.kind = K_STO; c.to_opnd = 1'b1; end
            OPC_LOAD:  begin c.kind = K_LD;  c.to_t = 1'b1; end
            OPC_LOADN: begin c.kind = K_LD;  c.to_t = 1'b1; c.inv = 1'b1; end
            default:   c.kind = K_NONE;
        endcase
        return c;
    endfunction

endpackage

// File: rtl/bitop_decode.sv
module bitop_decode
    import bitop_pkg::*;
(
    input  logic [OPC_W-1:0] op,
    output bctrl_t           ctrl
);
    always_comb begin
        ctrl = decode_op(op);
    end
endmodule

// File: rtl/bitop_locate.sv
module bitop_locate #(
    parameter int DATA_W   = 32,
    parameter int NARROW_W = 8,
    parameter int IDX_W    = $clog2(DATA_W)
) (
    input  logic              wide,
    input  logic [IDX_W-1:0]  idx,
    input  logic [DATA_W-1:0] operand,
    output logic [DATA_W-1:0] mask,
    output logic              sel_bit
);
    localparam int NIDX_W = $clog2(NARROW_W);

    logic [IDX_W-1:0] pos;

    // byte mode drops the upper index bits
    always_comb begin
        if (wide) pos = idx;
        else      pos = IDX_W'(idx[NIDX_W-1:0]);
    end

    for (genvar g = 0; g < DATA_W; g++) begin : g_mask
        assign mask[g] = (pos == IDX_W'(g));
    end

    assign sel_bit = |(operand & mask);
endmodule

// File: rtl/bitop_exec.sv
module bitop_exec
    import bitop_pkg::*;
#(
    parameter int DATA_W = 32
) (
    input  bctrl_t            ctrl,
    input  logic [DATA_W-1:0] operand,
    input  logic [DATA_W-1:0] mask,
    input  logic              sel_bit,
    input  logic              t_in,
    output logic [DATA_W-1:0] result,
    output logic              opnd_we,
    output logic              t_out,
    output logic              t_we
);
    logic bsrc;

    assign bsrc = sel_bit ^ ctrl.inv;

    always_comb begin
        result  = operand;
        t_out   = t_in;
        opnd_we = ctrl.to_opnd;
        t_we    = ctrl.to_t;
        case (ctrl.kind)
            K_AND: t_out  = t_in & bsrc;
            K_OR:  t_out  = t_in | bsrc;
            K_XOR: t_out  = t_in ^ bsrc;
            K_LD:  t_out  = bsrc;
            K_SET: result = operand | mask;
            K_CLR: result = operand & ~mask;
            K_STO: result = t_in ? (operand | mask) : (operand & ~mask);
            default: begin
                opnd_we = 1'b0;
                t_we    = 1'b0;
            end
        endcase
    end
endmodule

// File: rtl/bitop_unit.sv
module bitop_unit
    import bitop_pkg::*;
#(
    parameter int DATA_W   = 32,
    parameter int NARROW_W = 8,
    parameter int IDX_W    = $clog2(DATA_W),
    parameter bit REG_OUT  = 1'b1
) (
    input  logic              clk,
    input  logic              rst,
    input  logic [OPC_W-1:0]  op,
    input  logic              wide,
    input  logic [IDX_W-1:0]  idx,
    input  logic [DATA_W-1:0] operand,
    input  logic              t_in,
    output logic [DATA_W-1:0] result,
    output logic              opnd_we,
    output logic              t_out,
    output logic              t_we
);
    bctrl_t            ctrl;
    logic [DATA_W-1:0] mask;
    logic              sel_bit;
    logic [DATA_W-1:0] res_c;
    logic              owe_c, tout_c, twe_c;

    bitop_decode u_dec (
        .op   (op),
        .ctrl (ctrl)
    );

    bitop_locate #(
        .DATA_W(DATA_W), .NARROW_W(NARROW_W), .IDX_W(IDX_W)
    ) u_loc (
        .wide    (wide),
        .idx     (idx),
        .operand (operand),
        .mask    (mask),
        .sel_bit (sel_bit)
    );

    bitop_exec #(.DATA_W(DATA_W)) u_exe (
        .ctrl    (ctrl),
        .operand (operand),
        .mask    (mask),
        .sel_bit (sel_bit),
        .t_in    (t_in),
        .result  (res_c),
        .opnd_we (owe_c),
        .t_out   (tout_c),
        .t_we    (twe_c)
    );

    if (REG_OUT) begin : g_reg
        logic armed;

        always_ff @(posedge clk) begin
            if (rst) begin
                result  <= '0;
                opnd_we <= 1'b0;
                t_out   <= 1'b0;
                t_we    <= 1'b0;
                armed   <= 1'b0;
            end else begin
                result  <= res_c;
                opnd_we <= owe_c;
                t_out   <= tout_c;
                t_we    <= twe_c;
                armed   <= 1'b1;
            end
        end

        // R10
        strobe_excl_chk: assert property (@(posedge clk) disable iff (rst)
            $countones({opnd_we, t_we}) <= 1);

        // R8
        opnd_keep_chk: assert property (@(posedge clk) disable iff (rst)
            (armed && !opnd_we) |-> (result == $past(operand)));

        // R7
        t_keep_chk: assert property (@(posedge clk) disable iff (rst)
            (armed && !t_we) |-> (t_out == $past(t_in)));

        // R7
        single_bit_chk: assert property (@(posedge clk) disable iff (rst)
            (armed && opnd_we) |-> ($countones(result ^ $past(operand)) <= 1));

        // R6
        byte_upper_chk: assert property (@(posedge clk) disable iff (rst)
            (armed && !$past(wide)) |->
                (result[DATA_W-1:NARROW_W] == $past(operand[DATA_W-1:NARROW_W])));
    end else begin : g_comb
        assign result  = res_c;
        assign opnd_we = owe_c;
        assign t_out   = tout_c;
        assign t_we    = twe_c;
    end
endmodule

// File: tb/bitop_unit_test.sv
module bitop_unit_test;

    logic        clk = 1'b0;
    logic        rst = 1'b1;
    logic [3:0]  op = '0;
    logic        wide = 1'b0;
    logic [4:0]  idx = '0;
    logic [31:0] operand = '0;
    logic        t_in = 1'b0;
    logic [31:0] result;
    logic        opnd_we, t_out, t_we;

    int total = 0;
    int bad = 0;
    bit finished = 1'b0;

    always #2.5 clk = ~clk;

    bitop_unit uut (
        .clk(clk), .rst(rst), .op(op), .wide(wide), .idx(idx),
        .operand(operand), .t_in(t_in), .result(result),
        .opnd_we(opnd_we), .t_out(t_out), .t_we(t_we)
    );

    typedef struct packed {
        logic [3:0]  req;
        logic [3:0]  op;
        logic        wide;
        logic [4:0]  idx;
        logic [31:0] opnd;
        logic        t;
        logic [31:0] res;
        logic        we;
        logic        tout;
        logic        twe;
    } vec_t;

    localparam int NV = 15;
    localparam vec_t VECS [NV] = '{
        // R1 AND, bit set, T=1
        '{4'd1, 4'd0, 1'b0, 5'd3,  32'h0000_0008, 1'b1, 32'h0000_0008, 1'b0, 1'b1, 1'b1},
        // R1 AND, bit clear
        '{4'd1, 4'd0, 1'b0, 5'd3,  32'h0000_0000, 1'b1, 32'h0000_0000, 1'b0, 1'b0, 1'b1},
        // R1 OR at bit 31
        '{4'd1, 4'd1, 1'b1, 5'd31, 32'h8000_0000, 1'b0, 32'h8000_0000, 1'b0, 1'b1, 1'b1},
        // R1 XOR at bit 0
        '{4'd1, 4'd2, 1'b1, 5'd0,  32'h0000_0001, 1'b1, 32'h0000_0001, 1'b0, 1'b0, 1'b1},
        // R2 AND-NOT
        '{4'd2, 4'd3, 1'b0, 5'd7,  32'h0000_0000, 1'b1, 32'h0000_0000, 1'b0, 1'b1, 1'b1},
        // R2 OR-NOT
        '{4'd2, 4'd4, 1'b0, 5'd7,  32'h0000_0080, 1'b0, 32'h0000_0080, 1'b0, 1'b0, 1'b1},
        // R3 set bit 16
        '{4'd3, 4'd5, 1'b1, 5'd16, 32'h0000_0000, 1'b1, 32'h0001_0000, 1'b1, 1'b1, 1'b0},
        // R3 clear bit 16
        '{4'd3, 4'd6, 1'b1, 5'd16, 32'hFFFF_FFFF, 1'b0, 32'hFFFE_FFFF, 1'b1, 1'b0, 1'b0},
        // R4 store T=0 into byte bit 2
        '{4'd4, 4'd7, 1'b0, 5'd2,  32'h0000_00FF, 1'b0, 32'h0000_00FB, 1'b1, 1'b0, 1'b0},
        // R4 store T=1 into register bit 20
        '{4'd4, 4'd7, 1'b1, 5'd20, 32'h0000_0000, 1'b1, 32'h0010_0000, 1'b1, 1'b1, 1'b0},
        // R5 load bit 5
        '{4'd5, 4'd8, 1'b1, 5'd5,  32'h0000_0020, 1'b0, 32'h0000_0020, 1'b0, 1'b1, 1'b1},
        // R5 inverted load bit 5
        '{4'd5, 4'd9, 1'b0, 5'd5,  32'h0000_0020, 1'b1, 32'h0000_0020, 1'b0, 1'b0, 1'b1},
        // R6 byte set, idx 25 -> bit 1, upper bits pass
        '{4'd6, 4'd5, 1'b0, 5'd25, 32'hAB00_0000, 1'b1, 32'hAB00_0002, 1'b1, 1'b1, 1'b0},
        // R6 byte load, idx 9 -> bit 1 (bit 9 ignored)
        '{4'd6, 4'd8, 1'b0, 5'd9,  32'h0000_0200, 1'b1, 32'h0000_0200, 1'b0, 1'b0, 1'b1},
        // R9 reserved code 15
        '{4'd9, 4'd15, 1'b1, 5'd4, 32'h0000_1234, 1'b1, 32'h0000_1234, 1'b0, 1'b1, 1'b0}
    };

    task automatic check(input int rq, input logic [31:0] er, input logic ew,
                         input logic et, input logic etw);
        total++;
        if (result !== er || opnd_we !== ew || t_out !== et || t_we !== etw) begin
            bad++;
            $display("FAIL req R%0d: got res=%h we=%b t=%b twe=%b, exp res=%h we=%b t=%b twe=%b",
                     rq, result, opnd_we, t_out, t_we, er, ew, et, etw);
        end
    endtask

    initial begin : watchdog
        #100000;
        if (!finished) begin
            total++;
            bad++;
            $display("FAIL req R10: watchdog expired, got running exp done");
            $display("test done: total=%0d bad=%0d", total, bad);
            $finish;
        end
    end

    initial begin : main
        // R10 reset state with busy inputs
        op = 4'd5; wide = 1'b1; idx = 5'd3; operand = 32'hFFFF_0000; t_in = 1'b1;
        repeat (3) @(negedge clk);
        check(10, 32'h0, 1'b0, 1'b0, 1'b0);
        rst = 1'b0;

        for (int i = 0; i < NV; i++) begin
            @(negedge clk);
            op = VECS[i].op; wide = VECS[i].wide; idx = VECS[i].idx;
            operand = VECS[i].opnd; t_in = VECS[i].t;
            @(negedge clk);
            check(int'(VECS[i].req), VECS[i].res, VECS[i].we, VECS[i].tout, VECS[i].twe);
        end

        // R6 same index in register mode picks bit 9
        @(negedge clk);
        op = 4'd8; wide = 1'b1; idx = 5'd9; operand = 32'h0000_0200; t_in = 1'b0;
        @(negedge clk);
        check(6, 32'h0000_0200, 1'b0, 1'b1, 1'b1);

        // R7 store keeps other bits of a busy pattern
        @(negedge clk);
        op = 4'd7; wide = 1'b1; idx = 5'd8; operand = 32'h5A5A_A5A5; t_in = 1'b1;
        @(negedge clk);
        check(7, 32'h5A5A_A5A5 | 32'h100, 1'b1, 1'b1, 1'b0);

        // R8 load leaves a busy operand alone
        @(negedge clk);
        op = 4'd9; wide = 1'b1; idx = 5'd0; operand = 32'hDEAD_BEEF; t_in = 1'b1;
        @(negedge clk);
        check(8, 32'hDEAD_BEEF, 1'b0, 1'b0, 1'b1);

        // R9 reserved code 10
        @(negedge clk);
        op = 4'd10; wide = 1'b0; idx = 5'd1; operand = 32'h0000_00FF; t_in = 1'b0;
        @(negedge clk);
        check(9, 32'h0000_00FF, 1'b0, 1'b0, 1'b0);

        // R10 reset in the middle of activity
        @(negedge clk);
        op = 4'd5; wide = 1'b1; idx = 5'd4; operand = 32'h0; t_in = 1'b1; rst = 1'b1;
        @(negedge clk);
        check(10, 32'h0, 1'b0, 1'b0, 1'b0);
        rst = 1'b0;
        @(negedge clk);
        check(10, 32'h0000_0010, 1'b1, 1'b1, 1'b0);

        finished = 1'b1;
        $display("test done: total=%0d bad=%0d", total, bad);
        $finish;
    end

endmodule